// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the control engine of a single DMA channel. Software places a linked list of descriptors in host memory, programs a 64-bit pointer to the first one and then writes the channel's control/status word with enable, scatter-gather mode and start all set. The engine reads each descriptor one 32-bit word at a time over a request/response read port. For every descriptor that carries a non-zero byte count, it hands one transfer command to an external data mover and waits for that mover's completion handshake. It then follows the descriptor's next pointer.

Control flags travel in the low bits of the next pointer. A chain may point back to its own head, and the engine then cycles through it until it finds an end-of-chain flag or software aborts the walk. Each descriptor that asks for an interrupt raises a sticky interrupt flag once its transfer completes. The engine keeps a running total of the bytes moved, and software can read that total.

Top module: `sgd_chain_walker`

## Requirements
- R1: After reset the channel reads as done (CSR bit 4 = 1), the interrupt flag and `irq` are 0, the byte total reads 0, and neither `memReq` nor `xferReq` is asserted.
- R2: A CSR write (`regSel`=2) with bit 0 (enable), bit 1 (start) and bit 8 (scatter-gather mode) all set, accepted only while done, clears done and starts fetching at {pointer high, pointer low[31:5], 5'b0}. Pointer low is at `regSel`=0 and pointer high is at `regSel`=1. A start write that lacks enable or mode is ignored.
- R3: A descriptor is fetched as eight single-word reads at base+0, +4, … +28, with one read outstanding at a time. The words, in order, are: host address low, host address high, local word, reserved, byte count, reserved, next low, next high. `memReq` is never asserted together with `xferReq`.
- R4: For a descriptor with a non-zero count, `xferReq` rises after the eighth word and stays high, with stable `xferAddr` = {host high, host low}, `xferBytes` = count and `xferToHost` = next-low bit 3, until `xferDone`.
- R5: After a descriptor, the engine fetches next at {next high, next low[31:5], 5'b0}. If next-low bit 1 (end of chain) is set, it stops and sets done instead. A chain that points back to itself keeps cycling.
- R6: When a transfer completes for a descriptor with next-low bit 2 set, CSR bit 5 and `irq` go to 1 on the following cycle. Writing 1 to CSR bit 5 clears them.
- R7: A descriptor with byte count 0 issues no transfer command and raises no interrupt. The walk continues with its next pointer.
- R8: `regSel`=3 reads the total of the byte counts of completed transfers. An accepted start clears the total.
- R9: A CSR write with bit 2 (abort) while not done lets the current word read or transfer handshake finish, then stops with done set and no further requests. An abort while done has no effect.
- R10: The CSR read value has enable in bit 0, done in bit 4, the interrupt flag in bit 5, mode in bit 8, and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 CSR, 3 byte total |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regSel` (combinational) |
| memReq | output | 1 | Descriptor word read request (single cycle) |
| memAddr | output | 64 | Byte address of the requested word |
| memRspValid | input | 1 | Read response valid, at least one cycle after the request |
| memRspData | input | 32 | Read response word |
| xferReq | output | 1 | Transfer command valid, held until `xferDone` |
| xferAddr | output | 64 | Host byte address of the transfer |
| xferBytes | output | 32 | Transfer length in bytes |
| xferToHost | output | 1 | 1 = write toward host bus, 0 = read from it |
| xferDone | input | 1 | Data mover completion pulse |
| irq | output | 1 | Interrupt, level of the sticky flag |

## Verification
The bench walks a three-descriptor chain. Its middle descriptor has a zero count and carries an interrupt flag, so a design that issued that command or counted its bytes would show an extra scoreboard item or a wrong byte total. A descriptor whose next pointer leads back to itself is aborted while its fourth transfer is in flight. A design that dropped the pending handshake, stopped at chain end or kept fetching afterwards would fail the item count or the quiet-port check. A start pointer with dirty low bits checks the masking, and start writes without mode and abort writes while done check that the channel ignores them.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int DESC_WORDS  = 8;
  localparam int WIDX_W      = $clog2(DESC_WORDS);
  localparam int ALIGN_BITS  = 5;

  // word positions inside a descriptor
  localparam int W_HOST_LO = 0;
  localparam int W_HOST_HI = 1;
  localparam int W_COUNT   = 4;
  localparam int W_NEXT_LO = 6;
  localparam int W_NEXT_HI = 7;

  // flag positions in the next-pointer low word
  localparam int F_EOC   = 1;
  localparam int F_IRQ   = 2;
  localparam int F_TOHOST = 3;

  // control/status bit positions
  localparam int C_ENABLE = 0;
  localparam int C_START  = 1;
  localparam int C_ABORT  = 2;
  localparam int C_DONE   = 4;
  localparam int C_IRQ    = 5;
  localparam int C_SGMODE = 8;

  localparam logic [1:0] SEL_PTR_LO = 2'd0;
  localparam logic [1:0] SEL_PTR_HI = 2'd1;
  localparam logic [1:0] SEL_CSR    = 2'd2;
  localparam logic [1:0] SEL_BYTES  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_REQ, ST_FETCH_WAIT, ST_DECIDE, ST_XFER, ST_NEXT
  } walkState_t;

  typedef struct packed {
    logic beginWalk;
    logic captureWord;
    logic addBytes;
    logic raiseIrq;
    logic followNext;
  } walkStrobe_t;

  typedef struct packed {
    logic lastWord;
    logic zeroCount;
    logic endOfChain;
    logic irqWanted;
  } descStatus_t;
endpackage

// File: rtl/sgd_ctrl.sv
module sgd_ctrl
  import sgd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        abortReq,
  input  logic        memRspValid,
  input  logic        xferDone,
  input  descStatus_t descStat,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        xferReq,
  output logic        chanDone
);
  walkState_t state, stateNext;
  logic abortPend;
  logic abortSeen;
  logic goIdle;

  assign abortSeen = abortPend | (abortReq & ~chanDone);

  always_comb begin
    stateNext = state;
    goIdle    = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) stateNext = ST_FETCH_REQ;
      ST_FETCH_REQ: begin
        if (abortSeen) begin stateNext = ST_IDLE; goIdle = 1'b1; end
        else stateNext = ST_FETCH_WAIT;
      end
      ST_FETCH_WAIT: if (memRspValid) stateNext = descStat.lastWord ? ST_DECIDE : ST_FETCH_REQ;
      ST_DECIDE: begin
        if (abortSeen) begin stateNext = ST_IDLE; goIdle = 1'b1; end
        else if (descStat.zeroCount) stateNext = ST_NEXT;
        else stateNext = ST_XFER;
      end
      ST_XFER: if (xferDone) stateNext = ST_NEXT;
      ST_NEXT: begin
        if (abortSeen || descStat.endOfChain) begin stateNext = ST_IDLE; goIdle = 1'b1; end
        else stateNext = ST_FETCH_REQ;
      end
      default: begin stateNext = ST_IDLE; goIdle = 1'b1; end
    endcase
  end

  always_comb begin
    strobe             = '0;
    strobe.beginWalk   = (state == ST_IDLE) && startReq;
    strobe.captureWord = (state == ST_FETCH_WAIT) && memRspValid;
    strobe.addBytes    = (state == ST_XFER) && xferDone;
    strobe.raiseIrq    = (state == ST_XFER) && xferDone && descStat.irqWanted;
    strobe.followNext  = (state == ST_NEXT) && !abortSeen && !descStat.endOfChain;
  end

  assign memReq  = (state == ST_FETCH_REQ) && !abortSeen;
  assign xferReq = (state == ST_XFER);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chanDone  <= 1'b1;
      abortPend <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.beginWalk) chanDone <= 1'b0;
      else if (goIdle)      chanDone <= 1'b1;
      if (goIdle || state == ST_IDLE) abortPend <= 1'b0;
      else if (abortReq)              abortPend <= 1'b1;
    end
  end
endmodule

// File: rtl/sgd_dpath.sv
module sgd_dpath
  import sgd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              chanDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [DATA_W-1:0] xferBytes,
  output logic              xferToHost,
  output descStatus_t       descStat,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqFlag
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam int OFS_PAD = ADDR_W - WIDX_W - 2;

  logic [DATA_W-1:0] ptrLo, ptrHi;
  logic              enableBit, sgModeBit;
  logic [ADDR_W-1:0] curAddr;
  logic [WIDX_W-1:0] wordIdx;
  logic [DATA_W-1:0] descWord [DESC_WORDS];
  logic [CNT_W-1:0]  byteTotal;
  logic              csrWrite;

  assign csrWrite = regWrEn && (regSel == SEL_CSR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrLo     <= '0;
      ptrHi     <= '0;
      enableBit <= 1'b0;
      sgModeBit <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (regWrEn && regSel == SEL_PTR_LO) ptrLo <= regWrData;
      if (regWrEn && regSel == SEL_PTR_HI) ptrHi <= regWrData;
      if (csrWrite) begin
        enableBit <= regWrData[C_ENABLE];
        sgModeBit <= regWrData[C_SGMODE];
      end
      if (strobe.raiseIrq) irqFlag <= 1'b1;
      else if (csrWrite && regWrData[C_IRQ]) irqFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      wordIdx   <= '0;
      byteTotal <= '0;
    end else begin
      if (strobe.beginWalk) begin
        curAddr   <= {ptrHi[HI_W-1:0], ptrLo[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        wordIdx   <= '0;
        byteTotal <= '0;
      end else if (strobe.followNext) begin
        curAddr <= {descWord[W_NEXT_HI][HI_W-1:0],
                    descWord[W_NEXT_LO][DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        wordIdx <= '0;
      end else if (strobe.captureWord) begin
        wordIdx <= wordIdx + 1'b1;
      end
      if (strobe.addBytes) byteTotal <= byteTotal + CNT_W'(descWord[W_COUNT]);
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) descWord[g] <= '0;
      else if (strobe.captureWord && wordIdx == WIDX_W'(g)) descWord[g] <= memRspData;
    end
  end

  assign memAddr    = curAddr + {{OFS_PAD{1'b0}}, wordIdx, 2'b00};
  assign xferAddr   = {descWord[W_HOST_HI][HI_W-1:0], descWord[W_HOST_LO]};
  assign xferBytes  = descWord[W_COUNT];
  assign xferToHost = descWord[W_NEXT_LO][F_TOHOST];

  assign descStat.lastWord   = (wordIdx == WIDX_W'(DESC_WORDS - 1));
  assign descStat.zeroCount  = (descWord[W_COUNT] == '0);
  assign descStat.endOfChain = descWord[W_NEXT_LO][F_EOC];
  assign descStat.irqWanted  = descWord[W_NEXT_LO][F_IRQ];

  always_comb begin
    regRdData = '0;
    unique case (regSel)
      SEL_PTR_LO: regRdData = ptrLo;
      SEL_PTR_HI: regRdData = ptrHi;
      SEL_CSR: begin
        regRdData[C_ENABLE] = enableBit;
        regRdData[C_DONE]   = chanDone;
        regRdData[C_IRQ]    = irqFlag;
        regRdData[C_SGMODE] = sgModeBit;
      end
      default: regRdData = DATA_W'(byteTotal);
    endcase
  end
endmodule

// File: rtl/sgd_chain_walker.sv
module sgd_chain_walker
  import sgd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              xferReq,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [DATA_W-1:0] xferBytes,
  output logic              xferToHost,
  input  logic              xferDone,
  output logic              irq
);
  walkStrobe_t strobe;
  descStatus_t descStat;
  logic        chanDone;
  logic        startReq, abortReq, csrWrite;

  assign csrWrite = regWrEn && (regSel == SEL_CSR);
  assign startReq = csrWrite && regWrData[C_START] && regWrData[C_ENABLE] && regWrData[C_SGMODE];
  assign abortReq = csrWrite && regWrData[C_ABORT];

  sgd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .memRspValid(memRspValid), .xferDone(xferDone), .descStat(descStat),
    .strobe(strobe), .memReq(memReq), .xferReq(xferReq), .chanDone(chanDone)
  );

  sgd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .memRspData(memRspData), .chanDone(chanDone),
    .memAddr(memAddr), .xferAddr(xferAddr), .xferBytes(xferBytes),
    .xferToHost(xferToHost), .descStat(descStat), .regRdData(regRdData),
    .irqFlag(irq)
  );
endmodule

// File: rtl/sgd_chain_walker_chk.sv
module sgd_chain_walker_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              xferReq,
  input logic              xferDone,
  input logic [ADDR_W-1:0] xferAddr,
  input logic [DATA_W-1:0] xferBytes,
  input logic              irq,
  input logic              chanDone
);
  AST_EXCLUSIVE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && xferReq)); // R3
  AST_ALIGNED_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00); // R3
  AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && !xferDone) |=> (xferReq && $stable(xferAddr) && $stable(xferBytes))); // R4
  AST_NO_EMPTY_XFER: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |-> xferBytes != '0); // R7
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    chanDone |-> (!memReq && !xferReq)); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(xferReq && xferDone)); // R6
endmodule

bind sgd_chain_walker sgd_chain_walker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr), .xferReq(xferReq),
  .xferDone(xferDone), .xferAddr(xferAddr), .xferBytes(xferBytes), .irq(irq),
  .chanDone(chanDone)
);

// File: tb/sgd_chain_walker_test.sv
module sgd_chain_walker_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] bytes;
    logic        toHost;
  } xferItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq;
  logic [63:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        xferReq;
  logic [63:0] xferAddr;
  logic [31:0] xferBytes;
  logic        xferToHost;
  logic        xferDone = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int moverDelay = 3;
  int xferSeen = 0;
  logic [31:0] mem [0:1023];
  logic [63:0] reqLog [$];
  xferItem_t   expQ [$];
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgd_chain_walker uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .memReq(memReq), .memAddr(memAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .xferReq(xferReq), .xferAddr(xferAddr), .xferBytes(xferBytes),
    .xferToHost(xferToHost), .xferDone(xferDone), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // descriptor memory responder: one-cycle gap, then one-cycle response
  initial begin
    bit pending = 0;
    logic [63:0] pendAddr = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pending) begin
        memRspValid = 1'b1;
        memRspData  = mem[pendAddr[11:2]];
        pending = 0;
      end else if (memReq) begin
        pending  = 1;
        pendAddr = memAddr;
        reqLog.push_back(memAddr);
      end
    end
  end

  // data mover model
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      xferDone = 1'b0;
      if (xferReq) begin
        cnt++;
        if (cnt >= moverDelay) begin
          xferDone = 1'b1;
          cnt = 0;
        end
      end else cnt = 0;
    end
  end

  // scoreboard monitor
  always @(posedge xferDone) begin
    xferItem_t got;
    got = '{addr: xferAddr, bytes: xferBytes, toHost: xferToHost};
    xferSeen++;
    if (expQ.size() == 0) check(0, "R4 unexpected transfer", got.addr, 0);
    else begin
      xferItem_t e;
      e = expQ.pop_front();
      check(got.addr == e.addr, "R4 xfer address", got.addr, e.addr);
      check(got.bytes == e.bytes, "R4 xfer bytes", got.bytes, e.bytes);
      check(got.toHost == e.toHost, "R4 xfer direction", got.toHost, e.toHost);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    regSel = sel;
    #1;
    d = regRdData;
  endtask

  task automatic putDesc(input int base, input logic [31:0] hLo, input logic [31:0] hHi,
                         input logic [31:0] cnt, input logic [31:0] nLo);
    mem[base/4 + 0] = hLo;  mem[base/4 + 1] = hHi;
    mem[base/4 + 2] = 32'h5A5A5A5A; mem[base/4 + 3] = 0;
    mem[base/4 + 4] = cnt;  mem[base/4 + 5] = 0;
    mem[base/4 + 6] = nLo;  mem[base/4 + 7] = 0;
  endtask

  task automatic waitDone();
    logic [31:0] v;
    do begin
      @(negedge clk);
      rd(2'd2, v);
    end while (!v[4]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd2, v);
    check(v == 32'h10, "R1 R10 CSR after reset", v, 32'h10);
    rd(2'd3, v);
    check(v == 0, "R1 byte total after reset", v, 0);
    check(!irq && !memReq && !xferReq, "R1 outputs idle", {irq, memReq, xferReq}, 0);

    // R2 start without mode is ignored
    wr(2'd0, 32'h100);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h003);
    repeat (6) @(negedge clk);
    rd(2'd2, v);
    check(v[4] == 1'b1, "R2 start without mode keeps done", v, 32'h10);
    check(reqLog.size() == 0, "R2 no fetch without mode", reqLog.size(), 0);

    // three-descriptor chain: transfer, skipped zero count, final with eoc+irq
    putDesc(32'h100, 32'h1000, 32'hABCD0001, 64, 32'h120 | 32'h8);
    putDesc(32'h120, 32'h9999, 0, 0, 32'h140 | 32'h4);
    putDesc(32'h140, 32'h2000, 0, 128, 32'h2 | 32'h4);
    expQ.push_back('{addr: 64'hABCD0001_00001000, bytes: 64, toHost: 1'b1});
    expQ.push_back('{addr: 64'h2000, bytes: 128, toHost: 1'b0});
    xferSeen = 0;
    wr(2'd2, 32'h103);
    rd(2'd2, v);
    check(v[4] == 1'b0, "R2 done clears on start", v[4], 0);
    waitDone();
    for (int i = 0; i < 8; i++)
      check(reqLog[i] == 64'(32'h100 + 4*i), "R3 fetch word address", reqLog[i], 64'(32'h100 + 4*i));
    check(reqLog[8] == 64'h120 && reqLog[16] == 64'h140, "R5 next pointer followed",
          {reqLog[8][31:0], reqLog[16][31:0]}, {32'h120, 32'h140});
    check(reqLog.size() == 24, "R5 stop at end of chain", reqLog.size(), 24);
    check(xferSeen == 2 && expQ.size() == 0, "R7 zero count skipped", xferSeen, 2);
    rd(2'd3, v);
    check(v == 192, "R8 byte total", v, 192);
    rd(2'd2, v);
    check(v == 32'h131 && irq, "R6 R10 irq flag set", v, 32'h131);
    wr(2'd2, 32'h020);
    rd(2'd2, v);
    check(v[5] == 1'b0 && !irq, "R6 irq flag cleared", {v[5], irq}, 0);

    // R9 abort while done has no effect
    reqLog.delete();
    wr(2'd2, 32'h004);
    repeat (5) @(negedge clk);
    rd(2'd2, v);
    check(v[4] == 1'b1 && reqLog.size() == 0, "R9 abort while done ignored", v, 32'h10);

    // looping chain, aborted during the fourth transfer
    putDesc(32'h200, 32'h3000, 0, 16, 32'h200 | 32'h4 | 32'h8);
    for (int i = 0; i < 4; i++) expQ.push_back('{addr: 64'h3000, bytes: 16, toHost: 1'b1});
    xferSeen = 0;
    moverDelay = 10;
    wr(2'd0, 32'h200);
    wr(2'd2, 32'h103);
    wait (xferSeen == 3);
    do @(negedge clk); while (!xferReq);
    wr(2'd2, 32'h004);
    waitDone();
    check(xferSeen == 4 && expQ.size() == 0, "R9 R5 loop then abort finishes handshake", xferSeen, 4);
    rd(2'd3, v);
    check(v == 64, "R8 loop byte total", v, 64);
    check(irq == 1'b1, "R6 irq per flagged descriptor", irq, 1);
    reqLog.delete();
    repeat (20) @(negedge clk);
    check(reqLog.size() == 0 && !xferReq, "R9 quiet after abort", reqLog.size(), 0);
    wr(2'd2, 32'h020);

    // R2 start pointer low bits masked
    moverDelay = 2;
    putDesc(32'h300, 32'h4000, 0, 4, 32'h2);
    expQ.push_back('{addr: 64'h4000, bytes: 4, toHost: 1'b0});
    wr(2'd0, 32'h31F);
    wr(2'd2, 32'h103);
    waitDone();
    check(reqLog[0] == 64'h300, "R2 start pointer masked", reqLog[0], 64'h300);
    check(expQ.size() == 0 && !irq, "R6 no irq without flag", irq, 0);
    rd(2'd3, v);
    check(v == 4, "R8 total restarts", v, 4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule